// File: doc/BRIEF.md
# Polled Remote Request Ring

This block is the command intake of a storage controller. Remote senders place command entries by issuing memory-style writes, and each write names the ring slot it wants to fill. The ring holds sixteen slots. A write is stored only when it targets the slot the ring expects to fill next and that slot is empty. Every write is answered one cycle later with a one-cycle response pulse, which carries an error flag when the write was refused. The index of the next expected slot is visible to senders.

The local side never receives a doorbell. Instead, a polling engine waits a programmable number of cycles between polls. On each poll it looks at exactly one slot, which is the oldest one not yet drained. If that slot holds an entry, the engine moves the entry into a small local request queue and frees the slot. Polling pauses while the local queue is full, so an entry is never dropped. The entry at the head of the local queue is presented together with a decoded command class (read, write or invalid), and the local command engine removes it with a pop strobe.

Top module: `req_ring_poller`

## Requirements
- R1: While reset is high and on the first cycle after it, rsp_valid and lq_valid are 0, next_free is 0, and every ring slot is empty.
- R2: A cycle with wr_valid high is answered by exactly one rsp_valid pulse in the following cycle. rsp_valid is 0 in every cycle that does not follow a write cycle.
- R3: A write whose wr_slot equals next_free, and whose slot is empty, is stored. Its response has rsp_err = 0, and next_free advances by one, wrapping from 15 to 0, in the same cycle as the response.
- R4: A write whose wr_slot differs from next_free is refused. Its response has rsp_err = 1, nothing is stored, and next_free is unchanged.
- R5: A write to the expected slot while that slot is still full, because the ring has wrapped onto undrained work, is refused with rsp_err = 1 and does not change next_free.
- R6: Between polls the engine waits until its counter reaches poll_interval. With poll_interval = N, free room in the local queue, and a filled ring, successive entries reach the local queue N+1 cycles apart.
- R7: Entries leave the ring in slot index order, starting at slot 0 after reset. Each entry arrives in the local queue unchanged, and its slot becomes writable again once it has been drained.
- R8: The local queue holds 4 entries. While it is full, polling stops: no further slot is drained, a write to the next undrained slot is refused, and every stored entry is later delivered once each.
- R9: lq_kind decodes the opcode in bits [31:28] of lq_data: 4'h1 gives 0 (read), 4'h2 gives 1 (write), and any other value gives 2 (invalid).
- R10: lq_pop while lq_valid is 1 removes the head entry. The entries that remain are presented in arrival order, and lq_valid falls to 0 once the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | A remote write is presented this cycle |
| wr_slot | input | 4 | Ring slot targeted by the write |
| wr_data | input | 32 | Command entry carried by the write |
| rsp_valid | output | 1 | Response pulse for the previous cycle's write |
| rsp_err | output | 1 | The answered write was refused |
| next_free | output | 4 | Slot index the ring expects to fill next |
| poll_interval | input | 16 | Wait, in cycles, between polls |
| lq_valid | output | 1 | The local queue holds an entry |
| lq_data | output | 32 | Command entry at the local queue head |
| lq_kind | output | 2 | Decoded class of the head entry |
| lq_pop | input | 1 | Remove the head entry |

## Verification
The response to a write and the matching change of next_free both appear one cycle after the write cycle. The bench therefore drives each write at a falling edge and reads the response at the next falling edge. An entry taken on a poll edge is visible at the queue head at the falling edge just after that poll. The bench pops at the falling edge where it observes an entry and reads the next head one cycle later. Poll spacing is measured by stamping each arrival with a cycle count and comparing the differences against poll_interval plus one. Because each arrival is popped as soon as it is seen, the queue never fills during that measurement.

// File: rtl/rrq_pkg.sv
package rrq_pkg;

    localparam int OPC_W = 4;
    localparam logic [OPC_W-1:0] OPC_READ  = 4'h1;
    localparam logic [OPC_W-1:0] OPC_WRITE = 4'h2;

    typedef enum logic [1:0] {
        KIND_READ  = 2'd0,
        KIND_WRITE = 2'd1,
        KIND_BAD   = 2'd2
    } cmd_kind_e;

    typedef struct packed {
        logic valid;
        logic err;
    } ack_t;

    function automatic cmd_kind_e decode_kind(input logic [OPC_W-1:0] opc);
        case (opc)
            OPC_READ:  return KIND_READ;
            OPC_WRITE: return KIND_WRITE;
            default:   return KIND_BAD;
        endcase
    endfunction

endpackage

// File: rtl/rrq_slot_bank.sv
module rrq_slot_bank
    import rrq_pkg::*;
#(
    parameter int SLOTS   = 16,
    parameter int ENTRY_W = 32,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_valid,
    input  logic [SLOT_W-1:0]  wr_slot,
    input  logic [ENTRY_W-1:0] wr_data,
    input  logic               clr_valid,
    input  logic [SLOT_W-1:0]  rd_slot,
    output ack_t               ack,
    output logic [SLOT_W-1:0]  tail,
    output logic [SLOTS-1:0]   full_map,
    output logic [ENTRY_W-1:0] rd_data
);

    logic               accept;
    logic [SLOTS-1:0]   set_vec;
    logic [SLOTS-1:0]   clr_vec;
    logic [ENTRY_W-1:0] mem [SLOTS];

    // Store only on the expected slot, and only if it has been drained.
    assign accept = wr_valid && (wr_slot == tail) && !full_map[wr_slot];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        assign set_vec[g] = accept && (wr_slot == SLOT_W'(g));
        assign clr_vec[g] = clr_valid && (rd_slot == SLOT_W'(g));
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            mem[wr_slot] <= wr_data;
        end
    end

    // A slot cannot be set and cleared together: set needs empty, clear needs full.
    always_ff @(posedge clk) begin
        if (rst) begin
            full_map <= '0;
        end else begin
            full_map <= (full_map | set_vec) & ~clr_vec;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tail <= '0;
        end else if (accept) begin
            tail <= (tail == SLOT_W'(SLOTS - 1)) ? '0 : tail + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack <= '0;
        end else begin
            ack.valid <= wr_valid;
            ack.err   <= wr_valid && !accept;
        end
    end

    assign rd_data = mem[rd_slot];

endmodule

// File: rtl/rrq_poll_engine.sv
module rrq_poll_engine #(
    parameter int SLOTS   = 16,
    parameter int IVL_W   = 16,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IVL_W-1:0]  interval,
    input  logic [SLOTS-1:0]  full_map,
    input  logic              lq_full,
    output logic              take,
    output logic [SLOT_W-1:0] head
);

    logic [IVL_W-1:0] wait_cnt;
    logic             due;
    logic             fire;

    assign due  = (wait_cnt >= interval);
    assign fire = due && !lq_full;
    assign take = fire && full_map[head];

    // A due poll with a full local queue holds the counter, so the poll
    // happens in the first cycle in which the queue has room.
    always_ff @(posedge clk) begin
        if (rst) begin
            wait_cnt <= '0;
            head     <= '0;
        end else if (fire) begin
            wait_cnt <= '0;
            if (take) begin
                head <= (head == SLOT_W'(SLOTS - 1)) ? '0 : head + 1'b1;
            end
        end else if (!due) begin
            wait_cnt <= wait_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/rrq_local_fifo.sv
module rrq_local_fifo #(
    parameter int DEPTH  = 4,
    parameter int W      = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic             valid,
    output logic [W-1:0]     data,
    output logic             full,
    output logic [CNT_W-1:0] count
);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             do_push;
    logic             do_pop;

    assign valid   = (count != '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && valid;
    assign data    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

endmodule

// File: rtl/req_ring_poller.sv
module req_ring_poller
    import rrq_pkg::*;
#(
    parameter int SLOTS    = 16,
    parameter int ENTRY_W  = 32,
    parameter int LQ_DEPTH = 4,
    parameter int IVL_W    = 16,
    localparam int SLOT_W  = $clog2(SLOTS),
    localparam int CNT_W   = $clog2(LQ_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_valid,
    input  logic [SLOT_W-1:0]  wr_slot,
    input  logic [ENTRY_W-1:0] wr_data,
    output logic               rsp_valid,
    output logic               rsp_err,
    output logic [SLOT_W-1:0]  next_free,
    input  logic [IVL_W-1:0]   poll_interval,
    output logic               lq_valid,
    output logic [ENTRY_W-1:0] lq_data,
    output logic [1:0]         lq_kind,
    input  logic               lq_pop
);

    ack_t               ack;
    logic [SLOTS-1:0]   full_map;
    logic [ENTRY_W-1:0] slot_data;
    logic [SLOT_W-1:0]  head;
    logic               take;
    logic               lq_full;
    logic [CNT_W-1:0]   lq_count;

    rrq_slot_bank #(
        .SLOTS   (SLOTS),
        .ENTRY_W (ENTRY_W)
    ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_valid  (wr_valid),
        .wr_slot   (wr_slot),
        .wr_data   (wr_data),
        .clr_valid (take),
        .rd_slot   (head),
        .ack       (ack),
        .tail      (next_free),
        .full_map  (full_map),
        .rd_data   (slot_data)
    );

    rrq_poll_engine #(
        .SLOTS (SLOTS),
        .IVL_W (IVL_W)
    ) u_poll (
        .clk      (clk),
        .rst      (rst),
        .interval (poll_interval),
        .full_map (full_map),
        .lq_full  (lq_full),
        .take     (take),
        .head     (head)
    );

    rrq_local_fifo #(
        .DEPTH (LQ_DEPTH),
        .W     (ENTRY_W)
    ) u_lq (
        .clk       (clk),
        .rst       (rst),
        .push      (take),
        .push_data (slot_data),
        .pop       (lq_pop),
        .valid     (lq_valid),
        .data      (lq_data),
        .full      (lq_full),
        .count     (lq_count)
    );

    assign rsp_valid = ack.valid;
    assign rsp_err   = ack.err;
    assign lq_kind   = decode_kind(lq_data[ENTRY_W-1 -: OPC_W]);

endmodule

// File: rtl/req_ring_checks.sv
module req_ring_checks #(
    parameter int SLOTS    = 16,
    parameter int LQ_DEPTH = 4,
    localparam int SLOT_W  = $clog2(SLOTS),
    localparam int CNT_W   = $clog2(LQ_DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_valid,
    input logic [SLOT_W-1:0] wr_slot,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [SLOT_W-1:0] next_free,
    input logic              lq_valid,
    input logic [1:0]        lq_kind,
    input logic              take,
    input logic              lq_full,
    input logic [CNT_W-1:0]  lq_count
);

    a_r2_ack_follows: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> rsp_valid);

    a_r2_no_stray_ack: assert property (@(posedge clk) disable iff (rst)
        !wr_valid |=> !rsp_valid);

    a_r4_wrong_slot_err: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && (wr_slot != next_free)) |=> (rsp_valid && rsp_err));

    a_r4_err_keeps_tail: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err) |-> $stable(next_free));

    a_r3_tail_advance: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_err) |->
            (32'(next_free) == (32'($past(next_free)) + 32'd1) % SLOTS));

    a_r8_no_take_when_full: assert property (@(posedge clk) disable iff (rst)
        lq_full |-> !take);

    a_r8_depth_bound: assert property (@(posedge clk) disable iff (rst)
        32'(lq_count) <= LQ_DEPTH);

    a_r9_kind_legal: assert property (@(posedge clk) disable iff (rst)
        lq_valid |-> (lq_kind != 2'd3));

endmodule

bind req_ring_poller req_ring_checks #(
    .SLOTS    (SLOTS),
    .LQ_DEPTH (LQ_DEPTH)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_valid  (wr_valid),
    .wr_slot   (wr_slot),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .next_free (next_free),
    .lq_valid  (lq_valid),
    .lq_kind   (lq_kind),
    .take      (take),
    .lq_full   (lq_full),
    .lq_count  (lq_count)
);

// File: tb/req_ring_poller_test.sv
module req_ring_poller_test;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;

    // {slot, data, expected error, expected next_free afterwards}
    localparam logic [40:0] TBL [NVEC] = '{
        {4'd0,  32'h1000_00A0, 1'b0, 4'd1},
        {4'd1,  32'h2000_00A1, 1'b0, 4'd2},
        {4'd3,  32'h1000_00FF, 1'b1, 4'd2},
        {4'd2,  32'h3000_00A2, 1'b0, 4'd3},
        {4'd2,  32'h2000_00FE, 1'b1, 4'd3},
        {4'd15, 32'h1000_00FD, 1'b1, 4'd3},
        {4'd3,  32'h1000_00A3, 1'b0, 4'd4},
        {4'd4,  32'h2000_00A4, 1'b0, 4'd5}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_valid;
    logic [3:0]  wr_slot;
    logic [31:0] wr_data;
    logic        rsp_valid;
    logic        rsp_err;
    logic [3:0]  next_free;
    logic [15:0] poll_interval;
    logic        lq_valid;
    logic [31:0] lq_data;
    logic [1:0]  lq_kind;
    logic        lq_pop;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [31:0] exp_q [20];
    logic [31:0] sp_q  [3];
    int          stamp [3];

    req_ring_poller uut (
        .clk           (clk),
        .rst           (rst),
        .wr_valid      (wr_valid),
        .wr_slot       (wr_slot),
        .wr_data       (wr_data),
        .rsp_valid     (rsp_valid),
        .rsp_err       (rsp_err),
        .next_free     (next_free),
        .poll_interval (poll_interval),
        .lq_valid      (lq_valid),
        .lq_data       (lq_data),
        .lq_kind       (lq_kind),
        .lq_pop        (lq_pop)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [1:0] want_kind(input logic [31:0] d);
        if (d[31:28] == 4'h1) return 2'd0;
        if (d[31:28] == 4'h2) return 2'd1;
        return 2'd2;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [3:0] s, input logic [31:0] d,
                            output logic v, output logic e);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_slot  = s;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
        v = rsp_valid;
        e = rsp_err;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        logic v, e;
        int got, cyc;

        rst = 1'b1;
        wr_valid = 1'b0;
        wr_slot = '0;
        wr_data = '0;
        lq_pop = 1'b0;
        poll_interval = 16'hFFFF;
        repeat (3) @(negedge clk);
        check("R1 reset state", {rsp_valid, lq_valid, next_free}, 6'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after release", {rsp_valid, lq_valid, next_free}, 6'd0);

        // Vector table: polling is held off by the large interval.
        for (int i = 0; i < NVEC; i++) begin
            logic [3:0]  s;
            logic [31:0] d;
            logic        xe;
            logic [3:0]  xn;
            {s, d, xe, xn} = TBL[i];
            do_write(s, d, v, e);
            check("R2/R3/R4 table vector", {v, e, next_free}, {1'b1, xe, xn});
            if (!xe) exp_q[s] = d;
        end

        // Fill the rest of the ring: slots 5..15.
        for (int s = 5; s < 16; s++) begin
            logic [31:0] d;
            d = {(s % 3 == 0) ? 4'h1 : (s % 3 == 1) ? 4'h2 : 4'hC, 28'(s)};
            exp_q[s] = d;
            do_write(4'(s), d, v, e);
            check("R3 fill slot", {v, e, next_free}, {1'b1, 1'b0, 4'(s + 1)});
        end

        // R5: the ring has wrapped to slot 0, which is still full.
        do_write(4'd0, 32'h1000_0EEE, v, e);
        check("R5 wrap onto full slot", {v, e, next_free}, {1'b1, 1'b1, 4'd0});

        // R8: poll every cycle with no pops; the queue fills and polling stops.
        poll_interval = 16'd0;
        repeat (30) @(negedge clk);
        check("R8 queue head held", {lq_valid, lq_data}, {1'b1, exp_q[0]});
        check("R9 head kind read", lq_kind, 2'd0);
        for (int k = 0; k < 4; k++) begin
            logic [31:0] d;
            d = {(k % 2 == 0) ? 4'h2 : 4'h5, 20'h0, 8'hB0 + 8'(k)};
            exp_q[16 + k] = d;
            do_write(4'(k), d, v, e);
            check("R7 drained slot reusable", {v, e, next_free}, {1'b1, 1'b0, 4'(k + 1)});
        end
        do_write(4'd4, 32'h1000_0DDD, v, e);
        check("R8 stalled slot still full", {v, e, next_free}, {1'b1, 1'b1, 4'd4});
        check("R8 head unchanged while stalled", lq_data, exp_q[0]);

        // R7/R9/R10: drain everything through pops and check the order.
        got = 0;
        for (int c = 0; c < 400 && got < 20; c++) begin
            @(negedge clk);
            if (lq_valid) begin
                check("R7 order of delivery", lq_data, exp_q[got]);
                check("R9 command class", lq_kind, want_kind(exp_q[got]));
                got++;
                lq_pop = 1'b1;
            end else begin
                lq_pop = 1'b0;
            end
        end
        @(negedge clk);
        lq_pop = 1'b0;
        check("R8 no entry lost", got, 20);
        check("R10 queue empty after pops", lq_valid, 1'b0);

        // R6: spacing of polls with interval 5.
        poll_interval = 16'hFFFF;
        for (int k = 0; k < 3; k++) begin
            sp_q[k] = {4'h1, 20'h0, 8'hC0 + 8'(k)};
            do_write(4'(4 + k), sp_q[k], v, e);
        end
        check("R3 next_free after refill", next_free, 4'd7);
        @(negedge clk);
        poll_interval = 16'd5;
        got = 0;
        cyc = 0;
        for (int c = 0; c < 80 && got < 3; c++) begin
            @(negedge clk);
            cyc++;
            if (lq_valid) begin
                check("R6 spaced entry data", lq_data, sp_q[got]);
                stamp[got] = cyc;
                got++;
                lq_pop = 1'b1;
            end else begin
                lq_pop = 1'b0;
            end
        end
        @(negedge clk);
        lq_pop = 1'b0;
        check("R6 arrivals", got, 3);
        check("R6 first gap", stamp[1] - stamp[0], 6);
        check("R6 second gap", stamp[2] - stamp[1], 6);

        // R1: a later reset returns the ring to slot 0.
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset mid-run", {rsp_valid, lq_valid, next_free}, 6'd0);
        do_write(4'd7, 32'h1000_0777, v, e);
        check("R4 old slot refused after reset", {v, e, next_free}, {1'b1, 1'b1, 4'd0});

        done = 1;
        finish_run();
    end

endmodule